// File: doc/BRIEF.md
# Multi-Size Shift Execution Unit

This unit performs arithmetic and logical shifts, left and right, on 8-bit, 16-bit and 32-bit operands. It returns the shifted word, five condition flags (extend, negative, overflow, zero and carry) and the number of cycles the operation costs. The shift count comes from a 3-bit immediate field or from the low six bits of a register value. The count is therefore taken modulo 64, not modulo the operand width. Counts equal to or larger than the operand width get well-defined results and carries.

A separate memory form always shifts a 16-bit operand by exactly one position. In that form the size, count source, immediate and register count inputs are ignored. Decode, address generation and bus traffic are handled elsewhere. The unit accepts an operation when `in_valid` and `in_ready` are both high. One clock later it presents the result, flags and cycle count together for a single cycle.

Top module: `shift_unit`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low. An operation accepted at a clock edge raises `out_valid` for exactly one cycle after that edge, and `in_ready` is low during that cycle.
- R2: The count source is selected by `in_cnt_from_reg`. When it is 0, `in_imm` gives the count, with 1 to 7 meaning themselves and 0 meaning 8. When it is 1, only `in_reg_count[5:0]` is used, giving a count of 0 to 63.
- R3: Operation codes are `in_op` = 0 arithmetic left, 1 logical left, 2 arithmetic right, 3 logical right. Both left shifts fill with zeros and give the same result and flags. C is the last bit shifted out of the sized operand.
- R4: A logical right shift fills with zeros. C is the last bit shifted out at bit 0.
- R5: An arithmetic right shift fills with the operand's sign bit. For counts at or beyond the width, every result bit equals that sign bit, and so does C.
- R6: A logical shift of a long operand by exactly 32 gives zero. C is operand bit 0 for a left shift and bit 31 for a right shift.
- R7: A logical shift by more than the operand width gives zero, with C=0, Z=1 and N=0.
- R8: `out_flags` is {X,N,V,Z,C} from bit 4 down to bit 0. N is the top bit of the sized result, Z is set when the sized result is zero, and V is always 0.
- R9: For a nonzero count, X equals C. A count of zero returns the operand unchanged, clears C and copies `in_x` to X.
- R10: `in_size` is 0 for byte, 1 for word and 2 or 3 for long. Result bits above the selected size equal the operand bits.
- R11: `out_cycles` is 6 for byte or word and 8 for long, plus 2 per counted position.
- R12: With `in_mem` = 1, the operation is a word shift by one position costing 8 cycles, whatever the size and count inputs are.
- R13: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 2 | Shift kind (R3 encoding) |
| in_size | input | 2 | Operand size (R10 encoding) |
| in_mem | input | 1 | Memory form: word shifted by one |
| in_cnt_from_reg | input | 1 | Count taken from register value |
| in_imm | input | 3 | Immediate count, 0 means 8 |
| in_reg_count | input | 32 | Register holding the count |
| in_operand | input | 32 | Operand word |
| in_x | input | 1 | Current extend flag |
| out_valid | output | 1 | Single-cycle done pulse |
| out_result | output | 32 | Shifted word |
| out_flags | output | 5 | {X,N,V,Z,C} |
| out_cycles | output | 8 | Cycle cost of the operation |

## Verification
Random operands are run with random kinds, sizes and counts, including register counts across the whole 0 to 63 range. This separates sign fill from zero fill and shows whether upper bits are kept. Directed cases hit the counts 0, 8 (immediate zero), 32, 40, and a register value of 70 whose upper bits must be dropped. These cases tell apart correct modulo-64 handling from wrapping at the operand width. The memory form is tried with conflicting size and count inputs, and the count-zero case is run with X set, which shows whether X is left alone.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
   typedef enum logic [1:0] {
      OP_ASL = 2'd0,
      OP_LSL = 2'd1,
      OP_ASR = 2'd2,
      OP_LSR = 2'd3
   } shift_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } shift_size_e;

   typedef struct packed {
      logic x;
      logic n;
      logic v;
      logic z;
      logic c;
   } ccr_t;
endpackage

// File: rtl/shift_count_sel.sv
module shift_count_sel #(
   parameter int CNT_W      = 6,
   parameter int IMM_W      = 3,
   parameter int REG_W      = 32,
   parameter int CYC_W      = 8,
   parameter int BASE_SHORT = 6,
   parameter int BASE_LONG  = 8,
   parameter int PER_BIT    = 2
) (
   input  logic                         mem_form,
   input  logic                         from_reg,
   input  logic [IMM_W-1:0]             imm,
   input  logic [REG_W-1:0]             reg_count,
   input  shift_unit_pkg::shift_size_e  size,
   output logic [CNT_W-1:0]             count,
   output logic [CYC_W-1:0]             cycles
);
   localparam int IMM_MAX = 1 << IMM_W;
   localparam int MAX_CYC = BASE_LONG + PER_BIT * ((1 << CNT_W) - 1);

   if (CNT_W <= IMM_W) begin : g_bad_cnt
      $error("shift_count_sel: CNT_W must exceed IMM_W");
   end
   if (MAX_CYC >= (1 << CYC_W)) begin : g_bad_cyc
      $error("shift_count_sel: CYC_W too narrow for largest cost");
   end
   if (REG_W < CNT_W) begin : g_bad_reg
      $error("shift_count_sel: REG_W narrower than CNT_W");
   end

   logic [CYC_W-1:0] base;

   always_comb begin
      if (mem_form) begin
         count = CNT_W'(1);
      end else if (from_reg) begin
         count = reg_count[CNT_W-1:0];
      end else if (imm == '0) begin
         count = CNT_W'(IMM_MAX);
      end else begin
         count = {{(CNT_W-IMM_W){1'b0}}, imm};
      end
   end

   always_comb begin
      if (!mem_form && (size == shift_unit_pkg::SZ_LONG || size == shift_unit_pkg::SZ_RSVD)) begin
         base = CYC_W'(BASE_LONG);
      end else begin
         base = CYC_W'(BASE_SHORT);
      end
      cycles = base + CYC_W'(PER_BIT) * {{(CYC_W-CNT_W){1'b0}}, count};
   end
endmodule

// File: rtl/shift_lane.sv
module shift_lane #(
   parameter int W     = 8,
   parameter int CNT_W = 6
) (
   input  logic             left,
   input  logic             arith,
   input  logic [W-1:0]     opnd,
   input  logic [CNT_W-1:0] count,
   output logic [W-1:0]     res,
   output logic             carry
);
   localparam int EXT = 1 << CNT_W;

   logic [W+EXT-1:0] lv;
   logic [W+EXT:0]   rv;
   logic             fill;

   always_comb begin
      fill = arith & opnd[W-1];
      lv = {{EXT{1'b0}}, opnd} << count;
      rv = {{EXT{fill}}, opnd, 1'b0} >> count;
      if (left) begin
         res   = lv[W-1:0];
         carry = lv[W];
      end else begin
         res   = rv[W:1];
         carry = rv[0];
      end
   end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 6,
   parameter int N_SIZES = 3
) (
   input  logic                         left,
   input  logic                         arith,
   input  shift_unit_pkg::shift_size_e  size,
   input  logic [DATA_W-1:0]            opnd,
   input  logic [CNT_W-1:0]             count,
   output logic [DATA_W-1:0]            word,
   output logic                         neg,
   output logic                         zero,
   output logic                         carry
);
   localparam int SEL_W = (N_SIZES > 1) ? $clog2(N_SIZES) : 1;

   if (DATA_W != (8 << (N_SIZES-1))) begin : g_bad_width
      $error("shift_datapath: DATA_W must equal the widest lane");
   end

   logic [DATA_W-1:0] lane_word [N_SIZES];
   logic              lane_n    [N_SIZES];
   logic              lane_z    [N_SIZES];
   logic              lane_c    [N_SIZES];
   logic [SEL_W-1:0]  sel;

   for (genvar k = 0; k < N_SIZES; k++) begin : g_lane
      localparam int LW = 8 << k;
      logic [LW-1:0] res;
      shift_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
         .left  (left),
         .arith (arith),
         .opnd  (opnd[LW-1:0]),
         .count (count),
         .res   (res),
         .carry (lane_c[k])
      );
      if (LW < DATA_W) begin : g_keep
         assign lane_word[k] = {opnd[DATA_W-1:LW], res};
      end else begin : g_full
         assign lane_word[k] = res;
      end
      assign lane_n[k] = res[LW-1];
      assign lane_z[k] = (res == '0);
   end

   always_comb begin
      if (int'(size) >= N_SIZES) sel = SEL_W'(N_SIZES-1);
      else                       sel = SEL_W'(size);
      word  = lane_word[sel];
      neg   = lane_n[sel];
      zero  = lane_z[sel];
      carry = lane_c[sel];
   end
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 6,
   parameter int IMM_W      = 3,
   parameter int CYC_W      = 8,
   parameter int BASE_SHORT = 6,
   parameter int BASE_LONG  = 8,
   parameter int PER_BIT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_op,
   input  logic [1:0]        in_size,
   input  logic              in_mem,
   input  logic              in_cnt_from_reg,
   input  logic [IMM_W-1:0]  in_imm,
   input  logic [DATA_W-1:0] in_reg_count,
   input  logic [DATA_W-1:0] in_operand,
   input  logic              in_x,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic [4:0]        out_flags,
   output logic [CYC_W-1:0]  out_cycles
);
   import shift_unit_pkg::*;

   localparam int N_SIZES = 3;

   shift_op_e         op;
   shift_size_e       eff_size;
   logic [CNT_W-1:0]  count;
   logic [CYC_W-1:0]  cycles;
   logic [DATA_W-1:0] word;
   logic              neg, zero, carry, left, arith, accept;
   ccr_t              ccr;

   assign op       = shift_op_e'(in_op);
   assign eff_size = in_mem ? SZ_WORD : shift_size_e'(in_size);
   assign left     = (op == OP_ASL) || (op == OP_LSL);
   assign arith    = (op == OP_ASR);
   assign in_ready = !out_valid;
   assign accept   = in_valid && in_ready;

   shift_count_sel #(
      .CNT_W(CNT_W), .IMM_W(IMM_W), .REG_W(DATA_W), .CYC_W(CYC_W),
      .BASE_SHORT(BASE_SHORT), .BASE_LONG(BASE_LONG), .PER_BIT(PER_BIT)
   ) u_count (
      .mem_form  (in_mem),
      .from_reg  (in_cnt_from_reg),
      .imm       (in_imm),
      .reg_count (in_reg_count),
      .size      (eff_size),
      .count     (count),
      .cycles    (cycles)
   );

   shift_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .N_SIZES(N_SIZES)) u_dp (
      .left  (left),
      .arith (arith),
      .size  (eff_size),
      .opnd  (in_operand),
      .count (count),
      .word  (word),
      .neg   (neg),
      .zero  (zero),
      .carry (carry)
   );

   always_comb begin
      ccr.c = carry;
      ccr.z = zero;
      ccr.n = neg;
      ccr.v = 1'b0;
      ccr.x = (count == '0) ? in_x : carry;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_flags  <= '0;
         out_cycles <= '0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            out_result <= word;
            out_flags  <= ccr;
            out_cycles <= cycles;
         end
      end
   end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_ready,
   input logic [1:0]  in_op,
   input logic        in_mem,
   input logic        in_cnt_from_reg,
   input logic [31:0] in_reg_count,
   input logic        out_valid,
   input logic [4:0]  out_flags,
   input logic [7:0]  out_cycles
);
   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_accept_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   assert_v_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_flags[2]);

   // memory form: base 6 plus one position at 2 cycles
   assert_mem_cost_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_mem) |=> (out_cycles == 8'd8));

   assert_big_lsr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_mem && in_cnt_from_reg && in_op == 2'd3
       && in_reg_count[5:0] > 6'd32)
      |=> (out_flags[1] && !out_flags[0] && !out_flags[3]));

   assert_x_follows_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_mem) |=> (out_flags[4] == out_flags[0]));
endmodule

bind shift_unit shift_unit_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .in_valid        (in_valid),
   .in_ready        (in_ready),
   .in_op           (in_op),
   .in_mem          (in_mem),
   .in_cnt_from_reg (in_cnt_from_reg),
   .in_reg_count    (in_reg_count),
   .out_valid       (out_valid),
   .out_flags       (out_flags),
   .out_cycles      (out_cycles)
);

// File: tb/shift_unit_tb.sv
module shift_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = '0;
   logic [1:0]  in_size = '0;
   logic        in_mem = 1'b0;
   logic        in_cnt_from_reg = 1'b0;
   logic [2:0]  in_imm = '0;
   logic [31:0] in_reg_count = '0;
   logic [31:0] in_operand = '0;
   logic        in_x = 1'b0;
   logic        out_valid;
   logic [31:0] out_result;
   logic [4:0]  out_flags;
   logic [7:0]  out_cycles;

   int total = 0;
   int failed = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   shift_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_size(in_size), .in_mem(in_mem),
      .in_cnt_from_reg(in_cnt_from_reg), .in_imm(in_imm),
      .in_reg_count(in_reg_count), .in_operand(in_operand), .in_x(in_x),
      .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags),
      .out_cycles(out_cycles)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // bit-by-bit reference: {cycles, flags, result}
   function automatic logic [44:0] ref_calc(input logic [1:0] op, input logic [1:0] sz,
         input logic mem, input logic from_reg, input logic [2:0] imm,
         input logic [31:0] rc, input logic [31:0] opnd, input logic xin);
      int w, n, cyc;
      logic [31:0] mask, v;
      logic c, sgn, xo;
      if (mem) begin
         w = 16; n = 1;
      end else begin
         w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
         n = from_reg ? int'(rc[5:0]) : ((imm == 3'd0) ? 8 : int'(imm));
      end
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      v = opnd & mask;
      c = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (op < 2'd2) begin
            c = v[w-1];
            v = (v << 1) & mask;
         end else begin
            c = v[0];
            sgn = v[w-1];
            v = v >> 1;
            if (op == 2'd2 && sgn) v[w-1] = 1'b1;
         end
      end
      xo = (n == 0) ? xin : c;
      cyc = ((w == 32) ? 8 : 6) + 2 * n;
      return {8'(cyc), xo, v[w-1], 1'b0, (v == 32'd0), c, (opnd & ~mask) | v};
   endfunction

   task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input logic mem,
         input logic from_reg, input logic [2:0] imm, input logic [31:0] rc,
         input logic [31:0] opnd, input logic xin, input string req);
      logic [44:0] exp;
      exp = ref_calc(op, sz, mem, from_reg, imm, rc, opnd, xin);
      @(negedge clk);
      check("R1", "ready before offer", 64'(in_ready), 64'd1);
      in_valid = 1'b1; in_op = op; in_size = sz; in_mem = mem;
      in_cnt_from_reg = from_reg; in_imm = imm; in_reg_count = rc;
      in_operand = opnd; in_x = xin;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1", "done pulse", 64'(out_valid), 64'd1);
      check("R1", "ready during done", 64'(in_ready), 64'd0);
      check(req, "result", 64'(out_result), 64'(exp[31:0]));
      check(req, "flags", 64'(out_flags), 64'(exp[36:32]));
      check("R11", "cycles", 64'(out_cycles), 64'(exp[44:37]));
      @(negedge clk);
      check("R1", "pulse ends", 64'(out_valid), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; failed++;
         $display("FAIL R1 watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0005_EED1));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13", "valid after reset", 64'(out_valid), 64'd0);
      check("R13", "ready after reset", 64'(in_ready), 64'd1);

      // R6: long logical by exactly 32
      run_op(2'd1, 2'd2, 1'b0, 1'b1, 3'd0, 32'd32, 32'h0000_0001, 1'b0, "R6");
      run_op(2'd3, 2'd2, 1'b0, 1'b1, 3'd0, 32'd32, 32'h8000_0000, 1'b0, "R6");
      run_op(2'd0, 2'd2, 1'b0, 1'b1, 3'd0, 32'd32, 32'hFFFF_FFFE, 1'b1, "R6");
      // R7: beyond width
      run_op(2'd3, 2'd2, 1'b0, 1'b1, 3'd0, 32'd40, 32'hFFFF_FFFF, 1'b1, "R7");
      run_op(2'd1, 2'd1, 1'b0, 1'b1, 3'd0, 32'd20, 32'h0000_FFFF, 1'b0, "R7");
      run_op(2'd3, 2'd0, 1'b0, 1'b1, 3'd0, 32'd9, 32'h1234_56FF, 1'b0, "R7 R10");
      // R5: sign fill
      run_op(2'd2, 2'd2, 1'b0, 1'b1, 3'd0, 32'd40, 32'h8000_0000, 1'b0, "R5");
      run_op(2'd2, 2'd0, 1'b0, 1'b0, 3'd3, 32'd0, 32'h0000_0090, 1'b0, "R5");
      run_op(2'd2, 2'd1, 1'b0, 1'b1, 3'd0, 32'd63, 32'h0000_7FFF, 1'b1, "R5");
      // R4: logical right zero fill
      run_op(2'd3, 2'd0, 1'b0, 1'b0, 3'd3, 32'd0, 32'h0000_0090, 1'b0, "R4");
      // R3: arithmetic and logical left agree
      run_op(2'd0, 2'd1, 1'b0, 1'b0, 3'd4, 32'd0, 32'h0000_9ABC, 1'b0, "R3");
      run_op(2'd1, 2'd1, 1'b0, 1'b0, 3'd4, 32'd0, 32'h0000_9ABC, 1'b0, "R3");
      // R9: zero count keeps operand and X
      run_op(2'd1, 2'd2, 1'b0, 1'b1, 3'd0, 32'd64, 32'h8000_1234, 1'b1, "R9");
      run_op(2'd2, 2'd0, 1'b0, 1'b1, 3'd0, 32'd0, 32'h0000_0081, 1'b0, "R9");
      // R2: immediate zero means 8, register upper bits dropped
      run_op(2'd3, 2'd1, 1'b0, 1'b0, 3'd0, 32'd0, 32'h0000_A5C3, 1'b0, "R2");
      run_op(2'd1, 2'd2, 1'b0, 1'b1, 3'd0, 32'd70, 32'h0F0F_0F0F, 1'b0, "R2");
      // R10: upper bits kept
      run_op(2'd1, 2'd0, 1'b0, 1'b0, 3'd1, 32'd0, 32'hABCD_EF81, 1'b0, "R10");
      run_op(2'd2, 2'd1, 1'b0, 1'b0, 3'd2, 32'd0, 32'hDEAD_8001, 1'b0, "R10");
      // R8: flags N and Z
      run_op(2'd1, 2'd0, 1'b0, 1'b0, 3'd7, 32'd0, 32'h0000_0001, 1'b0, "R8");
      run_op(2'd1, 2'd0, 1'b0, 1'b0, 3'd1, 32'd0, 32'h0000_0080, 1'b0, "R8");
      // R12: memory form ignores size and count
      run_op(2'd0, 2'd0, 1'b1, 1'b0, 3'd5, 32'd0, 32'h1234_C001, 1'b0, "R12");
      run_op(2'd3, 2'd2, 1'b1, 1'b1, 3'd0, 32'd33, 32'hFFFF_8001, 1'b0, "R12");

      // random mix: R3 R4 R5 R8 R10 R11
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] rc;
         rc = $urandom;
         run_op(2'($urandom), 2'($urandom), ($urandom % 16) == 0, 1'($urandom),
                3'($urandom), rc, $urandom, 1'($urandom), "R3 R4 R5 R8 R10");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule